// File: doc/BRIEF.md
# Reconfiguration Mode Decision Controller

This block decides, once per time step, whether a self-adapting system should move to a different operating mode. It holds a table of candidate modes; each mode names a set of processing algorithms as a bitmask and carries a fitness score that is computed elsewhere. When enough time steps have passed since the last change and the measured efficiency of the current mode is too low, the controller draws a pseudo-random number. Depending on that draw, it picks either the fittest mode or a mode chosen at random with odds weighted by fitness. It then raises a one-cycle reconfigure request together with the index of the chosen mode.

The surrounding system pulses the step strobe once per time step. It presents the current mode index, the efficiency measured for that step and the fitness of every table entry, and it keeps the configuration inputs steady. The controller does not load or execute modes itself. It only announces which one should come next.

Top module: `mode_switch_ctl`

## Requirements
- R1: After reset, `reconf_o` is 0 and `next_mode_o` is 0.
- R2: Let K be the number of step strobes since the last decision, or since reset, not counting the strobe of that decision. A step can decide only when K >= `holdoff_i`. K saturates at 255.
- R3: A step can decide only when the efficiency is below the mode threshold. Efficiency is unsigned with 4 fraction bits. The threshold fraction is unsigned with 8 fraction bits. The test is `eff_i*16 < P*thr_frac_i`, where P is the popcount of the current mode's mask. Mode i's mask occupies `mode_mask_i[i*6 +: 6]`.
- R4: The random draw comes from a 16-bit shift register. It is seeded with 0xACE1 at reset and steps once on every strobe: new = {old[14:0], old[15]^old[13]^old[12]^old[10]}. A step uses the value held before its shift. The step exploits when draw <= `p_exploit_i` and explores otherwise.
- R5: Exploitation picks the valid mode with the largest fitness. Ties go to the lowest index. Mode i's fitness is `fit_i[i*8 +: 8]`, and mode i is valid when `mode_valid_i[i]` is 1. Invalid modes are never chosen.
- R6: Exploration forms S = (draw*T)>>16, where T is the sum of the valid fitnesses. It adds the valid fitnesses in index order and picks the first mode whose running sum exceeds S.
- R7: When T is 0, exploration falls back to the exploitation choice.
- R8: A decision needs at least one valid mode. It appears as `reconf_o` high for exactly the one cycle after the deciding strobe, with `next_mode_o` holding the chosen index. Without a decision, `reconf_o` stays 0 and `next_mode_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Time step strobe |
| eff_i | input | 8 | Efficiency of the current mode, 4 fraction bits |
| cur_mode_i | input | 3 | Index of the mode now running |
| mode_mask_i | input | 48 | Algorithm mask of each mode, 6 bits per mode |
| mode_valid_i | input | 8 | Table entry valid flags |
| fit_i | input | 64 | Fitness of each mode, 8 bits per mode |
| holdoff_i | input | 8 | Minimum steps between decisions |
| thr_frac_i | input | 8 | Threshold fraction per active algorithm, 8 fraction bits |
| p_exploit_i | input | 16 | Exploitation probability, scaled to 65536 |
| reconf_o | output | 1 | One-cycle reconfigure request |
| next_mode_o | output | 3 | Chosen mode index |

## Verification
Efficiency values are placed one unit on each side of the threshold for two masks with different popcounts, which shows that the threshold follows the active mode. Several fitness sets are tried. A distinct maximum checks the greedy search. Equal scores, with the best one marked invalid, check the tie rule and the valid filter. All-zero scores check the fallback. With the exploitation probability at zero, every draw goes through the weighted walk, so any error in the scaling or the ordering shows up as a wrong index. A mid-range probability mixes both paths over many steps. Strobes are sent back to back and with idle gaps, which checks the holdoff count and the shape of the request.

// File: rtl/msc_pkg.sv
package msc_pkg;
  localparam int RND_W = 16;

  typedef enum logic { PATH_GREEDY = 1'b0, PATH_ROULETTE = 1'b1 } path_e;

  function automatic logic [RND_W-1:0] rnd_advance(input logic [RND_W-1:0] s);
    return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/msc_lfsr.sv
module msc_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  output logic [15:0] value
);
  logic [15:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (adv) st_d = msc_pkg::rnd_advance(st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED;
    else        st_q <= st_d;
  end

  assign value = st_q;
endmodule

// File: rtl/msc_gate.sv
module msc_gate #(
  parameter int NUM_ALGOS = 6,
  parameter int EFF_W     = 8,
  parameter int EFF_FRAC  = 4,
  parameter int FRAC_W    = 8,
  parameter int HOLD_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 taken,
  input  logic [EFF_W-1:0]     eff,
  input  logic [NUM_ALGOS-1:0] cur_mask,
  input  logic [FRAC_W-1:0]    thr_frac,
  input  logic [HOLD_W-1:0]    holdoff,
  output logic                 hold_ok,
  output logic                 eff_low
);
  localparam int PC_W  = $clog2(NUM_ALGOS + 1);
  localparam int CMP_W = EFF_W + FRAC_W + PC_W + EFF_FRAC + 1;

  logic [HOLD_W-1:0] cnt_q, cnt_d;
  logic [PC_W-1:0]   pc;
  logic [CMP_W-1:0]  lhs, rhs;

  always_comb begin
    pc = '0;
    for (int i = 0; i < NUM_ALGOS; i++) pc = pc + PC_W'(cur_mask[i]);
  end

  always_comb begin
    lhs = CMP_W'(eff) << FRAC_W;
    rhs = (CMP_W'(pc) * CMP_W'(thr_frac)) << EFF_FRAC;
  end

  assign eff_low = lhs < rhs;
  assign hold_ok = cnt_q >= holdoff;

  always_comb begin
    cnt_d = cnt_q;
    if (step) begin
      if (taken)            cnt_d = '0;
      else if (~&cnt_q)     cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/msc_select.sv
module msc_select #(
  parameter int NUM_MODES = 8,
  parameter int FIT_W     = 8,
  parameter int RND_W     = 16
) (
  input  logic [NUM_MODES*FIT_W-1:0]   fit_flat,
  input  logic [NUM_MODES-1:0]         valid,
  input  logic [RND_W-1:0]             rnd,
  output logic [$clog2(NUM_MODES)-1:0] best_idx,
  output logic [$clog2(NUM_MODES)-1:0] wheel_idx,
  output logic                         any_valid,
  output logic                         total_zero
);
  localparam int IDX_W = $clog2(NUM_MODES);
  localparam int TOT_W = FIT_W + IDX_W + 1;
  localparam int PRD_W = TOT_W + RND_W;

  logic [FIT_W-1:0] fit [NUM_MODES];
  logic [FIT_W-1:0] best_f;
  logic [TOT_W-1:0] total, cum, scaled;
  logic [PRD_W-1:0] prod;
  logic             found, picked;

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_unpack
    assign fit[g] = fit_flat[g*FIT_W +: FIT_W];
  end

  always_comb begin
    best_idx = '0;
    best_f   = '0;
    found    = 1'b0;
    total    = '0;
    for (int i = 0; i < NUM_MODES; i++) begin
      if (valid[i]) begin
        total = total + TOT_W'(fit[i]);
        if (!found || fit[i] > best_f) begin
          found    = 1'b1;
          best_idx = IDX_W'(i);
          best_f   = fit[i];
        end
      end
    end
  end

  always_comb begin
    prod      = PRD_W'(rnd) * PRD_W'(total);
    scaled    = prod[PRD_W-1:RND_W];
    cum       = '0;
    picked    = 1'b0;
    wheel_idx = '0;
    for (int i = 0; i < NUM_MODES; i++) begin
      if (valid[i]) begin
        cum = cum + TOT_W'(fit[i]);
        if (!picked && cum > scaled) begin
          picked    = 1'b1;
          wheel_idx = IDX_W'(i);
        end
      end
    end
  end

  assign any_valid  = |valid;
  assign total_zero = (total == '0);
endmodule

// File: rtl/mode_switch_ctl.sv
module mode_switch_ctl #(
  parameter int          NUM_MODES = 8,
  parameter int          NUM_ALGOS = 6,
  parameter int          FIT_W     = 8,
  parameter int          EFF_W     = 8,
  parameter int          EFF_FRAC  = 4,
  parameter int          FRAC_W    = 8,
  parameter int          HOLD_W    = 8,
  parameter logic [15:0] SEED      = 16'hACE1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           step_i,
  input  logic [EFF_W-1:0]               eff_i,
  input  logic [$clog2(NUM_MODES)-1:0]   cur_mode_i,
  input  logic [NUM_MODES*NUM_ALGOS-1:0] mode_mask_i,
  input  logic [NUM_MODES-1:0]           mode_valid_i,
  input  logic [NUM_MODES*FIT_W-1:0]     fit_i,
  input  logic [HOLD_W-1:0]              holdoff_i,
  input  logic [FRAC_W-1:0]              thr_frac_i,
  input  logic [15:0]                    p_exploit_i,
  output logic                           reconf_o,
  output logic [$clog2(NUM_MODES)-1:0]   next_mode_o
);
  import msc_pkg::*;
  localparam int IDX_W = $clog2(NUM_MODES);

  logic [1:0]           rs_q;
  logic                 rst_s;
  logic [15:0]          lfsr_val;
  logic                 hold_ok, eff_low, any_valid, total_zero, decide;
  logic [IDX_W-1:0]     best_idx, wheel_idx, choice;
  logic [NUM_ALGOS-1:0] cur_mask;
  path_e                path;
  logic                 req_q, req_d;
  logic [IDX_W-1:0]     mode_q, mode_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  assign cur_mask = mode_mask_i[cur_mode_i*NUM_ALGOS +: NUM_ALGOS];

  msc_lfsr #(.SEED(SEED)) u_rng (
    .clk(clk), .rst_n(rst_s), .adv(step_i), .value(lfsr_val)
  );

  msc_gate #(
    .NUM_ALGOS(NUM_ALGOS), .EFF_W(EFF_W), .EFF_FRAC(EFF_FRAC),
    .FRAC_W(FRAC_W), .HOLD_W(HOLD_W)
  ) u_gate (
    .clk(clk), .rst_n(rst_s), .step(step_i), .taken(decide),
    .eff(eff_i), .cur_mask(cur_mask), .thr_frac(thr_frac_i),
    .holdoff(holdoff_i), .hold_ok(hold_ok), .eff_low(eff_low)
  );

  msc_select #(.NUM_MODES(NUM_MODES), .FIT_W(FIT_W), .RND_W(RND_W)) u_sel (
    .fit_flat(fit_i), .valid(mode_valid_i), .rnd(lfsr_val),
    .best_idx(best_idx), .wheel_idx(wheel_idx),
    .any_valid(any_valid), .total_zero(total_zero)
  );

  assign decide = step_i & hold_ok & eff_low & any_valid;

  always_comb begin
    path   = (lfsr_val <= p_exploit_i) ? PATH_GREEDY : PATH_ROULETTE;
    choice = (path == PATH_GREEDY || total_zero) ? best_idx : wheel_idx;
    req_d  = decide;
    mode_d = mode_q;
    if (decide) mode_d = choice;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      req_q  <= 1'b0;
      mode_q <= '0;
    end else begin
      req_q  <= req_d;
      mode_q <= mode_d;
    end
  end

  assign reconf_o    = req_q;
  assign next_mode_o = mode_q;
endmodule

// File: rtl/msc_checker.sv
module msc_checker #(
  parameter int NUM_MODES = 8,
  parameter int NUM_ALGOS = 6,
  parameter int EFF_W     = 8,
  parameter int EFF_FRAC  = 4,
  parameter int FRAC_W    = 8,
  parameter int HOLD_W    = 8
) (
  input logic                           clk,
  input logic                           rst_s,
  input logic                           step_i,
  input logic [EFF_W-1:0]               eff_i,
  input logic [$clog2(NUM_MODES)-1:0]   cur_mode_i,
  input logic [NUM_MODES*NUM_ALGOS-1:0] mode_mask_i,
  input logic [NUM_MODES-1:0]           mode_valid_i,
  input logic [HOLD_W-1:0]              holdoff_i,
  input logic [FRAC_W-1:0]              thr_frac_i,
  input logic                           reconf_o,
  input logic [$clog2(NUM_MODES)-1:0]   next_mode_o,
  input logic [15:0]                    lfsr_val
);
  logic [NUM_MODES-1:0] vld_q;
  logic [15:0]          gap_q, gap_eff;
  logic [31:0]          pc, lim, scaled_eff;
  logic                 below;

  always_comb begin
    pc = 0;
    for (int i = 0; i < NUM_ALGOS; i++)
      pc = pc + 32'(mode_mask_i[32'(cur_mode_i)*NUM_ALGOS + i]);
    lim        = (pc * 32'(thr_frac_i)) * (32'd1 << EFF_FRAC);
    scaled_eff = 32'(eff_i) * (32'd1 << FRAC_W);
    below      = scaled_eff < lim;
    gap_eff    = reconf_o ? 16'd0 : gap_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      vld_q <= '0;
      gap_q <= '0;
    end else begin
      vld_q <= mode_valid_i;
      if (step_i && gap_eff != 16'hFFFF) gap_q <= gap_eff + 16'd1;
      else                               gap_q <= gap_eff;
    end
  end

  p_pulse_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_s)
    reconf_o |-> $past(step_i));
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_s)
    !reconf_o |-> $stable(next_mode_o));
  p_pick_valid_r5: assert property (@(posedge clk) disable iff (!rst_s)
    reconf_o |-> vld_q[next_mode_o]);
  p_rng_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_s)
    lfsr_val != 16'd0);
  p_holdoff_r2: assert property (@(posedge clk) disable iff (!rst_s)
    reconf_o |-> $past(gap_eff) >= 16'($past(holdoff_i)));
  p_eff_gate_r3: assert property (@(posedge clk) disable iff (!rst_s)
    reconf_o |-> $past(below));
endmodule

bind mode_switch_ctl msc_checker #(
  .NUM_MODES(NUM_MODES), .NUM_ALGOS(NUM_ALGOS), .EFF_W(EFF_W),
  .EFF_FRAC(EFF_FRAC), .FRAC_W(FRAC_W), .HOLD_W(HOLD_W)
) u_chk (
  .clk(clk), .rst_s(rst_s), .step_i(step_i), .eff_i(eff_i),
  .cur_mode_i(cur_mode_i), .mode_mask_i(mode_mask_i),
  .mode_valid_i(mode_valid_i), .holdoff_i(holdoff_i),
  .thr_frac_i(thr_frac_i), .reconf_o(reconf_o),
  .next_mode_o(next_mode_o), .lfsr_val(lfsr_val)
);

// File: tb/mode_switch_ctl_bench.sv
module mode_switch_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0;
  logic [7:0]  eff_i = '0;
  logic [2:0]  cur_mode_i = '0;
  logic [47:0] mode_mask_i;
  logic [7:0]  mode_valid_i = 8'hFF;
  logic [63:0] fit_i;
  logic [7:0]  holdoff_i = '0;
  logic [7:0]  thr_frac_i = 8'd192;
  logic [15:0] p_exploit_i = 16'hFFFF;
  logic        reconf_o;
  logic [2:0]  next_mode_o;

  logic [7:0] fit_a [8];
  logic [5:0] mask_a [8];

  always_comb
    for (int i = 0; i < 8; i++) begin
      fit_i[i*8 +: 8]       = fit_a[i];
      mode_mask_i[i*6 +: 6] = mask_a[i];
    end

  mode_switch_ctl u_mode_switch_ctl (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .eff_i(eff_i),
    .cur_mode_i(cur_mode_i), .mode_mask_i(mode_mask_i),
    .mode_valid_i(mode_valid_i), .fit_i(fit_i), .holdoff_i(holdoff_i),
    .thr_frac_i(thr_frac_i), .p_exploit_i(p_exploit_i),
    .reconf_o(reconf_o), .next_mode_o(next_mode_o)
  );

  always #4 clk = ~clk;

  typedef struct { bit req; int mode; string tag; } exp_t;
  exp_t exp_q [$];

  int checks = 0;
  int fails  = 0;
  bit live   = 0;
  bit step_d = 0;

  int m_rng  = 16'hACE1;
  int m_cnt  = 0;
  int m_mode = 0;

  always @(posedge clk) step_d <= step_i;

  always @(negedge clk) begin
    if (live) begin
      if (step_d) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R8 result with no expectation: req=%0d exp=none", reconf_o);
        end else begin
          e = exp_q.pop_front();
          checks++;
          if (reconf_o !== e.req || (e.req && next_mode_o !== 3'(e.mode)) ||
              (!e.req && next_mode_o !== 3'(e.mode))) begin
            fails++;
            $display("FAIL %s req=%0d mode=%0d expected req=%0d mode=%0d",
                     e.tag, reconf_o, next_mode_o, e.req, e.mode);
          end
        end
      end else if (reconf_o !== 1'b0) begin
        checks++; fails++;
        $display("FAIL R8 request without strobe: req=%0d expected 0", reconf_o);
      end
    end
  end

  // Bench model built from the requirement text.
  task automatic strobe(input string tag, input int gap);
    exp_t e;
    int draw, pc, tot, best, bestf, cum, pick, sc, anyv, choice;
    bit decide;
    draw  = m_rng;
    m_rng = ((m_rng << 1) & 16'hFFFF) |
            (((m_rng >> 15) ^ (m_rng >> 13) ^ (m_rng >> 12) ^ (m_rng >> 10)) & 1);
    pc = 0;
    for (int i = 0; i < 6; i++) pc += int'(mask_a[cur_mode_i][i]);
    anyv = 0; tot = 0; best = 0; bestf = -1;
    for (int i = 0; i < 8; i++)
      if (mode_valid_i[i]) begin
        anyv = 1; tot += int'(fit_a[i]);
        if (int'(fit_a[i]) > bestf) begin bestf = int'(fit_a[i]); best = i; end
      end
    decide = (m_cnt >= int'(holdoff_i)) && (int'(eff_i) * 16 < pc * int'(thr_frac_i)) && (anyv != 0);
    choice = best;
    if (draw > int'(p_exploit_i) && tot != 0) begin
      sc = int'((longint'(draw) * longint'(tot)) >> 16);
      cum = 0; pick = -1;
      for (int i = 0; i < 8; i++)
        if (mode_valid_i[i]) begin
          cum += int'(fit_a[i]);
          if (pick < 0 && cum > sc) pick = i;
        end
      choice = pick;
    end
    if (decide) begin m_cnt = 0; m_mode = choice; end
    else if (m_cnt < 255) m_cnt++;
    e.req = decide; e.mode = m_mode; e.tag = tag;
    exp_q.push_back(e);
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    for (int k = 0; k < gap; k++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      mask_a[i] = 6'((1 << (i % 6 + 1)) - 1);
      fit_a[i]  = 8'(10 + 7 * i);
    end
    fit_a[5] = 8'd200;
    cur_mode_i = 3'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (reconf_o !== 1'b0 || next_mode_o !== 3'd0) begin
      fails++;
      $display("FAIL R1 req=%0d mode=%0d expected req=0 mode=0", reconf_o, next_mode_o);
    end
    live = 1;

    // R2 holdoff of three, then greedy pick of mode 5 (R5)
    holdoff_i = 8'd3; eff_i = 8'd10;
    for (int s = 0; s < 4; s++) strobe("R2", 1);
    strobe("R2", 2);

    // R3 threshold edges for popcount 4 and popcount 1
    holdoff_i = 8'd0;
    eff_i = 8'd48; strobe("R3", 1);
    eff_i = 8'd47; strobe("R3", 1);
    cur_mode_i = 3'd0;
    eff_i = 8'd12; strobe("R3", 0);
    eff_i = 8'd11; strobe("R3", 2);
    cur_mode_i = 3'd3; eff_i = 8'd5;

    // R5 ties and invalid exclusion
    for (int i = 0; i < 8; i++) fit_a[i] = 8'd50;
    fit_a[1] = 8'd200; mode_valid_i = 8'b1111_1101;
    strobe("R5", 1);
    mode_valid_i = 8'b1111_1100;
    strobe("R5", 0);

    // R6 weighted choice on every draw
    p_exploit_i = 16'h0000; mode_valid_i = 8'hFF;
    for (int i = 0; i < 8; i++) fit_a[i] = 8'(5 + 30 * i);
    for (int s = 0; s < 10; s++) strobe("R6", s % 3);
    fit_a[2] = 8'd0; fit_a[6] = 8'd255; mode_valid_i = 8'b1011_0111;
    for (int s = 0; s < 6; s++) strobe("R6", 0);

    // R7 zero total falls back to lowest valid index
    for (int i = 0; i < 8; i++) fit_a[i] = 8'd0;
    mode_valid_i = 8'b0011_0000;
    strobe("R7", 1);
    strobe("R7", 0);

    // R8 empty table: no request, random source still steps
    mode_valid_i = 8'h00;
    strobe("R8", 1);
    strobe("R8", 0);

    // R4 mixed paths over many draws, holdoff two
    mode_valid_i = 8'hFF; p_exploit_i = 16'h8000; holdoff_i = 8'd2;
    for (int i = 0; i < 8; i++) fit_a[i] = 8'(17 * i + 3);
    for (int s = 0; s < 40; s++) begin
      eff_i = (s % 5 == 0) ? 8'd90 : 8'd20;
      strobe("R4", s % 4);
    end

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule